// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the word address for burst accesses to a synchronous SRAM. A full base address is captured whenever either of two active-low strobes, one from the processor side and one from a cache controller side, is low at a rising clock edge. After that, each edge with the active-low advance input low moves the burst forward by one beat. Only the two lowest address bits change during a burst. All bits above them keep the loaded value.

A static order input chooses how the two low bits are sequenced. When it is low, the beats follow a linear count that wraps around four. When it is high, which is the default setting, the beats follow an interleaved order: the start bits exclusive-ORed with the beat count. The block also outputs the beat index, so a caller can tell where in the four-beat group the current address falls. A new base address may be captured on every cycle, and bursting is optional.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rstN` is low, and at the first edge after it, `addrOut` and `beatIdx` are both zero.
- R2: A rising edge with `procStrobeN` low or `ctrlStrobeN` low sets `addrOut` to `addrIn` and `beatIdx` to 0 at that edge.
- R3: When both strobes are low in the same cycle, the block performs one load, exactly as R2 describes, with no extra count.
- R4: A strobe has priority over advance. If a strobe and `advanceN` are both low, the block loads and does not step.
- R5: At an edge with no strobe low and `advanceN` low, `beatIdx` becomes (`beatIdx` + 1) mod 4.
- R6: With `orderSel` low (linear order), `addrOut[1:0]` equals (start LSBs + `beatIdx`) mod 4. For example, a start of 1 gives 1,2,3,0.
- R7: With `orderSel` high (interleaved order), `addrOut[1:0]` equals start LSBs XOR `beatIdx`. For example, a start of 1 gives 1,0,3,2.
- R8: `addrOut[ADDR_W-1:2]` changes only at a load edge.
- R9: At an edge with no strobe low and `advanceN` high, `addrOut` and `beatIdx` hold their values.
- R10: After the fourth beat, continued advance wraps `beatIdx` to 0. The address then repeats the same order from the loaded start.
- R11: Loads on consecutive cycles each take effect at their own edge, with no dead cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous active-low reset |
| procStrobeN | input | 1 | Processor-side address strobe, active low |
| ctrlStrobeN | input | 1 | Controller-side address strobe, active low |
| advanceN | input | 1 | Burst advance, active low |
| orderSel | input | 1 | Burst order: 0 = linear, 1 = interleaved |
| addrIn | input | ADDR_W | Base address captured at a load |
| addrOut | output | ADDR_W | Current burst word address |
| beatIdx | output | 2 | Beat index within the four-beat burst |

## Verification
Loading and advancing can be requested in the same cycle, and so can the two strobes. The random stimulus drives each strobe and the advance input low with independent probabilities, so all of these overlaps occur often. Directed cycles also force both strobes together with advance low. Each such edge is judged against a bench model in which any strobe wins. The expected result is the new base address with beat index zero, with no trace of a step or a second load.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // Strobes passed from the control decode to the datapath.
  typedef struct packed {
    logic load;  // capture a new base address
    logic step;  // advance the burst by one beat
  } burstCtl_t;

  localparam int BEAT_W = 2;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_seq_pkg::*;
(
  input  logic      procStrobeN,
  input  logic      ctrlStrobeN,
  input  logic      advanceN,
  output burstCtl_t ctl
);
  logic anyStrobe;

  // Either strobe loads. Two strobes together still give one load.
  assign anyStrobe = ~procStrobeN | ~ctrlStrobeN;

  always_comb begin
    ctl.load = anyStrobe;
    ctl.step = ~anyStrobe & ~advanceN;  // a load wins over a step
  end
endmodule

// File: rtl/burst_seq_datapath.sv
module burst_seq_datapath
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  burstCtl_t         ctl,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic [BEAT_W-1:0] beatIdx
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [UPPER_W-1:0] upperQ;
  logic [BEAT_W-1:0]  startQ;
  logic [BEAT_W-1:0]  beatQ;
  logic [BEAT_W-1:0]  linLsb;
  logic [BEAT_W-1:0]  intlvLsb;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upperQ <= '0;
      startQ <= '0;
      beatQ  <= '0;
    end else if (ctl.load) begin
      upperQ <= addrIn[ADDR_W-1:BEAT_W];
      startQ <= addrIn[BEAT_W-1:0];
      beatQ  <= '0;
    end else if (ctl.step) begin
      beatQ  <= BEAT_W'(beatQ + 1'b1);
    end
  end

  // Both orders are computed; the order input picks one of them.
  assign linLsb   = BEAT_W'(startQ + beatQ);
  assign intlvLsb = startQ ^ beatQ;

  assign addrOut = {upperQ, (orderSel ? intlvLsb : linLsb)};
  assign beatIdx = beatQ;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advanceN,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic [1:0]        beatIdx
);
  burstCtl_t ctl;

  burst_seq_ctrl u_ctrl (
    .procStrobeN(procStrobeN),
    .ctrlStrobeN(ctrlStrobeN),
    .advanceN   (advanceN),
    .ctl        (ctl)
  );

  burst_seq_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .orderSel(orderSel),
    .addrIn  (addrIn),
    .addrOut (addrOut),
    .beatIdx (beatIdx)
  );
endmodule

// File: rtl/burst_seq_checker.sv
module burst_seq_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              procStrobeN,
  input logic              ctrlStrobeN,
  input logic              advanceN,
  input logic              orderSel,
  input logic [ADDR_W-1:0] addrIn,
  input logic [ADDR_W-1:0] addrOut,
  input logic [1:0]        beatIdx
);
  logic isLoad;
  logic isStep;
  logic isIdle;
  assign isLoad = !procStrobeN || !ctrlStrobeN;
  assign isStep = !isLoad && !advanceN;
  assign isIdle = !isLoad && advanceN;

  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    isLoad |=> (addrOut == $past(addrIn) && beatIdx == 2'd0));

  assert_single_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!procStrobeN && !ctrlStrobeN && !advanceN) |=> beatIdx == 2'd0);

  assert_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    isStep |=> beatIdx == 2'($past(beatIdx) + 2'd1));

  assert_linear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (isStep && !orderSel) ##1 !orderSel |->
      addrOut[1:0] == 2'($past(addrOut[1:0]) + 2'd1));

  assert_interleave_R7: assert property (@(posedge clk) disable iff (!rstN)
    (isStep && orderSel) ##1 orderSel |->
      (addrOut[1:0] ^ beatIdx) == $past(addrOut[1:0] ^ beatIdx));

  assert_upper_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    !isLoad |=> $stable(addrOut[ADDR_W-1:2]));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (isIdle ##1 $stable(orderSel)) |-> ($stable(addrOut) && $stable(beatIdx)));
endmodule

bind burst_addr_seq burst_seq_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .procStrobeN(procStrobeN),
  .ctrlStrobeN(ctrlStrobeN),
  .advanceN   (advanceN),
  .orderSel   (orderSel),
  .addrIn     (addrIn),
  .addrOut    (addrOut),
  .beatIdx    (beatIdx)
);

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          procStrobeN = 1'b1;
  logic          ctrlStrobeN = 1'b1;
  logic          advanceN = 1'b1;
  logic          orderSel = 1'b1;
  logic [AW-1:0] addrIn = '0;
  logic [AW-1:0] addrOut;
  logic [1:0]    beatIdx;

  int checks = 0;
  int fails = 0;
  logic done = 1'b0;

  // Bench model of the burst state.
  logic [AW-3:0] mUpper = '0;
  logic [1:0]    mStart = '0;
  logic [1:0]    mBeat = '0;

  always #4 clk = ~clk;  // 125 MHz

  burst_addr_seq #(.ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN),
    .advanceN(advanceN), .orderSel(orderSel), .addrIn(addrIn),
    .addrOut(addrOut), .beatIdx(beatIdx)
  );

  function automatic logic [1:0] expLsb(logic [1:0] s, logic [1:0] b, logic ord);
    return ord ? (s ^ b) : 2'(s + b);
  endfunction

  function automatic logic [AW-1:0] expAddr();
    return {mUpper, expLsb(mStart, mBeat, orderSel)};
  endfunction

  task automatic chk(string req, logic [AW-1:0] got, logic [AW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // One cycle: drive at negedge, let the edge pass, update the model,
  // then compare at the next negedge.
  task automatic cycle(logic p, logic c, logic a, logic [AW-1:0] ad, string req);
    procStrobeN = p; ctrlStrobeN = c; advanceN = a; addrIn = ad;
    @(posedge clk);
    if (!p || !c) begin
      mUpper = ad[AW-1:2]; mStart = ad[1:0]; mBeat = 2'd0;
    end else if (!a) begin
      mBeat = 2'(mBeat + 1);
    end
    @(negedge clk);
    chk(req, addrOut, expAddr());
    chk(req, {{(AW-2){1'b0}}, beatIdx}, {{(AW-2){1'b0}}, mBeat});
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    // R1: reset state, then the first edge after release
    chk("R1", addrOut, '0);
    chk("R1", {{(AW-2){1'b0}}, beatIdx}, '0);
    @(negedge clk);
    rstN = 1'b1;
    cycle(1, 1, 1, 20'hABCDE, "R1");

    // R6 and R10: linear from start 1 gives 1,2,3,0, then wraps
    orderSel = 1'b0;
    cycle(0, 1, 1, 20'h12341, "R2");
    chk("R6", {18'd0, addrOut[1:0]}, 20'd1);
    for (int i = 0; i < 6; i++) cycle(1, 1, 0, 20'h0, (i >= 3) ? "R10" : "R6");
    chk("R10", {18'd0, addrOut[1:0]}, 20'd3);  // beat 2 after wrap: 1+2

    // R7 and R10: interleaved from start 1 gives 1,0,3,2
    orderSel = 1'b1;
    cycle(1, 0, 1, 20'h55551, "R2");
    cycle(1, 1, 0, 20'h0, "R7");
    chk("R7", {18'd0, addrOut[1:0]}, 20'd0);
    cycle(1, 1, 0, 20'h0, "R7");
    chk("R7", {18'd0, addrOut[1:0]}, 20'd3);
    for (int i = 0; i < 4; i++) cycle(1, 1, 0, 20'h0, "R10");
    chk("R10", {18'd0, addrOut[1:0]}, 20'd3);

    // R9: hold
    cycle(1, 1, 1, 20'hFFFFF, "R9");
    cycle(1, 1, 1, 20'h00000, "R9");
    // R3 and R4: both strobes with advance low give one load
    cycle(0, 0, 0, 20'h3C3C2, "R3");
    cycle(0, 1, 0, 20'h11113, "R4");
    // R11: back-to-back loads
    cycle(0, 1, 1, 20'h22220, "R11");
    cycle(1, 0, 1, 20'h33331, "R11");
    cycle(0, 1, 1, 20'h44442, "R11");
    // R8: steps keep the upper bits
    cycle(1, 1, 0, 20'hFFFFF, "R8");
    chk("R8", {2'd0, addrOut[AW-1:2]}, {2'd0, 18'h11110});

    // Random phase: the order changes only between segments
    for (int seg = 0; seg < 40; seg++) begin
      orderSel = 1'($urandom_range(0, 1));
      for (int i = 0; i < 50; i++) begin
        logic p, c, a;
        string req;
        p = ($urandom_range(0, 9) < 2) ? 1'b0 : 1'b1;
        c = ($urandom_range(0, 9) < 2) ? 1'b0 : 1'b1;
        a = ($urandom_range(0, 9) < 6) ? 1'b0 : 1'b1;
        if (!p && !c)      req = "R3";
        else if (!p || !c) req = a ? "R2" : "R4";
        else if (!a)       req = orderSel ? "R7" : "R5";
        else               req = "R9";
        cycle(p, c, a, AW'($urandom), req);
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule